// File: doc/BRIEF.md
# Two's-Complement Add/Subtract/Negate Unit

A purely combinational arithmetic unit for signed operands of a configurable width. A two-bit operation code picks one of four operations: plain addition, subtraction, negation of the first operand, or a widened addition that returns a result one bit wider than the operands. Every operation runs through a single ripple adder that is one bit wider than the operands. Subtraction inverts the second operand and forces the carry-in high. Negation adds one to the inverted first operand. The narrow result is the low bits of the adder output, and the extra top bit is discarded.

The unit reports four status flags: carry-out, signed overflow, negative and zero. In the narrow operations, overflow is the XOR of the carries into and out of the sign bit. Negating the most negative value keeps its bit pattern and raises overflow. The widened output always carries the exact (WIDTH+1)-bit value, so a neighbour can also test overflow by comparing its top two bits.

Top module: `tcau_top`

## Requirements
- R1: With `op_sel` = 2'b00, `res` equals (op_a + op_b) mod 2^WIDTH, and `flag_c` is the carry out of bit WIDTH-1 of the unsigned sum.
- R2: With `op_sel` = 2'b01, `res` equals (op_a - op_b) mod 2^WIDTH, computed as op_a + ~op_b + 1. `flag_c` is the carry out of that sum, so it is 1 exactly when no borrow occurs. Subtracting a value from itself gives zero with `flag_c` = 1.
- R3: In the narrow operations (codes 00, 01, 10), `flag_v` is 1 exactly when the true signed result lies outside -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R4: With `op_sel` = 2'b10, `res` equals (~op_a + 1) mod 2^WIDTH and `op_b` has no effect on any output. Negating zero gives zero with `flag_c` = 1 and `flag_v` = 0.
- R5: Negating the most negative value (only the sign bit set) returns the same pattern with `flag_v` = 1.
- R6: With `op_sel` = 2'b11, both operands are sign-extended to WIDTH+1 bits and added. `res_wide` is the exact signed sum, `res` holds its low WIDTH bits, `flag_v` is always 0, and `flag_c` is the carry out of bit WIDTH of the extended sum.
- R7: `flag_n` is the sign bit of the active result: bit WIDTH-1 of `res` in the narrow operations and bit WIDTH of `res_wide` in the widened one. `flag_z` is 1 when every bit of the active result is zero.
- R8: In the narrow operations, `res_wide` holds the exact signed result in WIDTH+1 bits, and its low WIDTH bits equal `res`. Its top two bits differ exactly when `flag_v` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 negate op_a, 11 widened add |
| op_a | input | WIDTH | First signed operand |
| op_b | input | WIDTH | Second signed operand (unused for negate) |
| res | output | WIDTH | Narrow result |
| res_wide | output | WIDTH+1 | Exact result one bit wider |
| flag_c | output | 1 | Carry out of the active top bit |
| flag_v | output | 1 | Signed overflow of the narrow result |
| flag_n | output | 1 | Sign bit of the active result |
| flag_z | output | 1 | Active result is all zeros |

## Verification
The unit has no registers, so every result and flag is due in the same cycle as the operands that produce it. The driver changes the inputs just after a rising edge and pushes the expected item onto the queue at the same moment. The monitor pops and compares at the following falling edge, half a period later, once the inputs have settled. The expected values come from integer arithmetic on the signed values, not from adder bits, and they cover directed corners (zero, both extremes, self-subtraction, negate with varying op_b) and a long pseudo-random run of each operation.

// File: rtl/tcau_pkg.sv
package tcau_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_NEG  = 2'b10,
        OP_WADD = 2'b11
    } tcau_op_e;
endpackage

// File: rtl/tcau_prep.sv
// Operand conditioning: sign-extends to WIDTH+1 and applies inversion / carry-in
module tcau_prep
    import tcau_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  tcau_op_e         op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH:0]   x,
    output logic [WIDTH:0]   y,
    output logic             cin
);
    logic [WIDTH:0] a_ext;
    logic [WIDTH:0] b_ext;

    assign a_ext = {a[WIDTH-1], a};
    assign b_ext = {b[WIDTH-1], b};

    always_comb begin
        unique case (op)
            OP_ADD: begin
                x   = a_ext;
                y   = b_ext;
                cin = 1'b0;
            end
            OP_SUB: begin
                x   = a_ext;
                y   = ~b_ext;
                cin = 1'b1;
            end
            OP_NEG: begin
                x   = ~a_ext;
                y   = '0;
                cin = 1'b1;
            end
            OP_WADD: begin
                x   = a_ext;
                y   = b_ext;
                cin = 1'b0;
            end
            default: begin
                x   = a_ext;
                y   = b_ext;
                cin = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tcau_adder.sv
// Ripple adder exposing the carry into every bit position
module tcau_adder #(
    parameter int LEN = 9
) (
    input  logic [LEN-1:0] x,
    input  logic [LEN-1:0] y,
    input  logic           cin,
    output logic [LEN-1:0] sum,
    output logic [LEN:0]   carry
);
    assign carry[0] = cin;

    for (genvar i = 0; i < LEN; i++) begin : g_bit
        logic prop;
        assign prop         = x[i] ^ y[i];
        assign sum[i]       = prop ^ carry[i];
        assign carry[i + 1] = (x[i] & y[i]) | (carry[i] & prop);
    end
endmodule

// File: rtl/tcau_flags.sv
// Status flags from the adder sum and carry chain
module tcau_flags
    import tcau_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  tcau_op_e         op,
    input  logic [WIDTH:0]   sum,
    input  logic [WIDTH+1:0] carry,
    output logic             c,
    output logic             v,
    output logic             n,
    output logic             z
);
    always_comb begin
        unique case (op)
            OP_WADD: begin
                c = carry[WIDTH+1];
                v = 1'b0;
                n = sum[WIDTH];
                z = (sum == '0);
            end
            default: begin
                c = carry[WIDTH];
                v = carry[WIDTH] ^ carry[WIDTH-1];
                n = sum[WIDTH-1];
                z = (sum[WIDTH-1:0] == '0);
            end
        endcase
    end
endmodule

// File: rtl/tcau_top.sv
module tcau_top
    import tcau_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] res,
    output logic [WIDTH:0]   res_wide,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_n,
    output logic             flag_z
);
    localparam int LEN = WIDTH + 1;

    tcau_op_e       op;
    logic [LEN-1:0] x_in;
    logic [LEN-1:0] y_in;
    logic           cin;
    logic [LEN-1:0] sum;
    logic [LEN:0]   carry;

    assign op = tcau_op_e'(op_sel);

    tcau_prep #(.WIDTH(WIDTH)) u_prep (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .x   (x_in),
        .y   (y_in),
        .cin (cin)
    );

    tcau_adder #(.LEN(LEN)) u_add (
        .x     (x_in),
        .y     (y_in),
        .cin   (cin),
        .sum   (sum),
        .carry (carry)
    );

    tcau_flags #(.WIDTH(WIDTH)) u_flags (
        .op    (op),
        .sum   (sum),
        .carry (carry),
        .c     (flag_c),
        .v     (flag_v),
        .n     (flag_n),
        .z     (flag_z)
    );

    assign res      = sum[WIDTH-1:0];
    assign res_wide = sum;
endmodule

// File: rtl/tcau_chk.sv
module tcau_chk #(
    parameter int WIDTH = 8
) (
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] res,
    input logic [WIDTH:0]   res_wide,
    input logic             flag_c,
    input logic             flag_v,
    input logic             flag_n,
    input logic             flag_z
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    always_comb begin
        if (op_sel != 2'b11) begin
            p_top_pair_matches_v_r8: assert (flag_v == (res_wide[WIDTH] != res_wide[WIDTH-1]))
                else $error("R8: top bits of res_wide disagree with flag_v");
            p_low_bits_match_r8: assert (res == res_wide[WIDTH-1:0])
                else $error("R8: res differs from low bits of res_wide");
        end
        if (op_sel == 2'b11) begin
            p_no_overflow_r6: assert (!flag_v)
                else $error("R6: widened add raised overflow");
        end
        if (op_sel == 2'b10 && op_a == MOST_NEG) begin
            p_neg_min_ovf_r5: assert (res == op_a && flag_v)
                else $error("R5: negate of most negative value wrong");
        end
        if (op_sel == 2'b10 && op_a == '0) begin
            p_neg_zero_r4: assert (res == '0 && !flag_v && flag_c)
                else $error("R4: negate of zero wrong");
        end
        if (op_sel == 2'b01 && op_a == op_b) begin
            p_sub_self_r2: assert (res == '0 && flag_c && flag_z)
                else $error("R2: self subtraction wrong");
        end
    end
endmodule

bind tcau_top tcau_chk #(.WIDTH(WIDTH)) u_chk (
    .op_sel   (op_sel),
    .op_a     (op_a),
    .op_b     (op_b),
    .res      (res),
    .res_wide (res_wide),
    .flag_c   (flag_c),
    .flag_v   (flag_v),
    .flag_n   (flag_n),
    .flag_z   (flag_z)
);

// File: tb/tcau_top_tb.sv
`timescale 1ns/1ps
module tcau_top_tb;
    localparam int WIDTH = 8;
    localparam longint MASK  = (64'sd1 <<< WIDTH) - 1;
    localparam longint MASKW = (64'sd1 <<< (WIDTH + 1)) - 1;
    localparam longint SMAX  = (64'sd1 <<< (WIDTH - 1)) - 1;
    localparam longint SMIN  = -(64'sd1 <<< (WIDTH - 1));
    localparam int WATCHDOG  = 100000;

    typedef struct {
        logic [1:0]       op;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] res;
        logic [WIDTH:0]   wide;
        logic             c;
        logic             v;
        logic             n;
        logic             z;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]       op_sel = 2'b00;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic [WIDTH-1:0] res;
    logic [WIDTH:0]   res_wide;
    logic flag_c, flag_v, flag_n, flag_z;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    exp_t sb_q[$];
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    tcau_top #(.WIDTH(WIDTH)) u_dut (
        .op_sel   (op_sel),
        .op_a     (op_a),
        .op_b     (op_b),
        .res      (res),
        .res_wide (res_wide),
        .flag_c   (flag_c),
        .flag_v   (flag_v),
        .flag_n   (flag_n),
        .flag_z   (flag_z)
    );

    function automatic longint sval(logic [WIDTH-1:0] x);
        return x[WIDTH-1] ? longint'(x) - (64'sd1 <<< WIDTH) : longint'(x);
    endfunction

    function automatic exp_t model(logic [1:0] op, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
        exp_t e;
        longint sa = sval(a);
        longint sb = sval(b);
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint raw;
        longint exact;
        e.op = op; e.a = a; e.b = b;
        case (op)
            2'b00: begin raw = ua + ub;                 exact = sa + sb; end
            2'b01: begin raw = ua + ((~ub) & MASK) + 1; exact = sa - sb; end
            2'b10: begin raw = ((~ua) & MASK) + 1;      exact = -sa;     end
            default: begin raw = (sa & MASKW) + (sb & MASKW); exact = sa + sb; end
        endcase
        e.res  = WIDTH'(exact & MASK);
        e.wide = (WIDTH+1)'(exact & MASKW);
        if (op == 2'b11) begin
            e.c = raw[WIDTH+1];
            e.v = 1'b0;
            e.n = e.wide[WIDTH];
            e.z = (e.wide == '0);
        end else begin
            e.c = raw[WIDTH];
            e.v = (exact > SMAX) || (exact < SMIN);
            e.n = e.res[WIDTH-1];
            e.z = (e.res == '0);
        end
        return e;
    endfunction

    task automatic send(logic [1:0] op, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
        @(posedge clk);
        #1;
        op_sel = op; op_a = a; op_b = b;
        sb_q.push_back(model(op, a, b));
    endtask

    function automatic string req_of(logic [1:0] op);
        case (op)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic cmp(string req, longint act, longint exp, exp_t e, string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h",
                     req, what, e.op, e.a, e.b, act, exp);
        end
    endtask

    // Monitor: results are combinational, due half a period after the drive
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            string vreq;
            e = sb_q.pop_front();
            cmp(req_of(e.op), longint'(res), longint'(e.res), e, "res");
            cmp((e.op == 2'b11) ? "R6" : "R8", longint'(res_wide), longint'(e.wide), e, "res_wide");
            cmp(req_of(e.op), longint'(flag_c), longint'(e.c), e, "carry");
            vreq = (e.op == 2'b11) ? "R6" : ((e.op == 2'b10 && e.a == WIDTH'(SMIN & MASK)) ? "R5" : "R3");
            cmp(vreq, longint'(flag_v), longint'(e.v), e, "overflow");
            cmp("R7", longint'(flag_n), longint'(e.n), e, "negative");
            cmp("R7", longint'(flag_z), longint'(e.z), e, "zero");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic logic [WIDTH-1:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return WIDTH'(seed[30:16]);
    endfunction

    initial begin
        logic [WIDTH-1:0] mn = WIDTH'(SMIN & MASK);
        logic [WIDTH-1:0] mx = WIDTH'(SMAX);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // idle inputs: zero add, zero flag expected (R7)
        send(2'b00, '0, '0);
        // R1 add corners and R3 overflow both directions
        send(2'b00, 8'd3, 8'hFF);
        send(2'b00, mx, 8'd1);
        send(2'b00, mn, mn);
        send(2'b00, mx, mn);
        // R2 subtraction, borrow, self, overflow (R3)
        send(2'b01, 8'd15, 8'd35);
        send(2'b01, 8'd77, 8'd77);
        send(2'b01, mn, 8'd1);
        send(2'b01, mx, 8'hFF);
        send(2'b01, '0, mn);
        // R4 negate; op_b varied must not matter
        send(2'b10, '0, '0);
        send(2'b10, '0, 8'hA5);
        send(2'b10, 8'd5, 8'h00);
        send(2'b10, 8'd5, 8'hFF);
        send(2'b10, mx, 8'h3C);
        // R5 negate most negative
        send(2'b10, mn, 8'h00);
        send(2'b10, mn, 8'h7E);
        // R6 widened add extremes
        send(2'b11, mx, mx);
        send(2'b11, mn, mn);
        send(2'b11, mx, mn);
        send(2'b11, '0, '0);
        send(2'b11, 8'hFF, 8'd1);
        for (int i = 0; i < 1200; i++) begin
            send(2'(i % 4), rnd(), rnd());
        end
        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            mismatched++;
            $display("FAIL scoreboard not drained: actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule